// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the address for a four-beat synchronous burst to a memory. A new burst begins on either of two active-low start strobes: one driven by the processor and one by the cache controller. Both are qualified by an active-low chip enable. On a start, the full external address is captured. From then on, only the two least significant bits move, and each move is one beat taken while the active-low advance input is asserted. The upper address bits stay at their captured value until the next start.

The beat order is chosen per burst by the `interleave` input, which is sampled together with the start address. Linear order adds the beat number to the starting low bits, modulo 4. Interleaved order XORs the beat number into the starting low bits. All inputs are sampled on the rising clock edge. The output address comes from registered state through one small add-or-XOR stage.

Top module: `burst_addr_seq`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, the stored address, beat number and order select all clear, so `addrOut` reads 0 after that edge.
- R2: With `chipEnN` low, a rising edge at which `procStrobeN` or `ctrlStrobeN` is low loads `addrIn`, so `addrOut` equals that `addrIn` after the edge (beat 0).
- R3: With `chipEnN` high, both start strobes are ignored. No load happens, and `advanceN` acts exactly as if no strobe were present.
- R4: A load takes precedence over an advance. When both start strobes are low together, or a start strobe coincides with a low `advanceN`, the edge is a load: `addrOut` equals `addrIn` and no step is taken.
- R5: With `interleave` = 0 captured at the load, each advance edge sets `addrOut[1:0]` to the previous `addrOut[1:0]` plus 1, modulo 4. From start s, the beats are s, s+1, s+2, s+3.
- R6: With `interleave` = 1 captured at the load, beat n has `addrOut[1:0]` = s XOR n, where s is the loaded low pair. From s = 1, the beats are 1, 0, 3, 2.
- R7: An advance never changes `addrOut[ADDR_W-1:2]`. A fifth advance after the fourth beat wraps back to the start address of the burst.
- R8: At an edge with no accepted start strobe and `advanceN` high, `addrOut` stays unchanged.
- R9: `interleave` is sampled only on a load edge. Changing it during a burst does not alter the order of that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| chipEnN | input | 1 | Chip enable, active low; qualifies both start strobes |
| procStrobeN | input | 1 | Processor burst-start strobe, active low, higher priority |
| ctrlStrobeN | input | 1 | Cache-controller burst-start strobe, active low |
| advanceN | input | 1 | Beat advance, active low |
| interleave | input | 1 | Beat order for the next load: 0 linear, 1 interleaved |
| addrIn | input | ADDR_W | External start address |
| addrOut | output | ADDR_W | Current burst address |

## Verification
A load and an advance can be requested in the same cycle, and so can the two start strobes. Directed tasks raise `advanceN` low together with one or both strobes in the middle of a running burst. The result is judged correct only if `addrOut` shows the new start address exactly, with its low pair unstepped. A further scenario holds `advanceN` low while a strobe is presented with the chip deselected. There the advance must win, which confirms that a disqualified strobe leaves no trace.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes from the control decode to the address datapath.
  typedef struct packed {
    logic load;     // capture a new start address and order
    logic advance;  // step the beat counter by one
  } seqCtl_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
(
  input  logic    chipEnN,
  input  logic    procStrobeN,
  input  logic    ctrlStrobeN,
  input  logic    advanceN,
  output seqCtl_t ctl
);
  logic procHit;
  logic ctrlHit;

  // Both starts need the chip selected. The processor strobe is listed first
  // for priority, but both resolve to the same load.
  always_comb begin
    procHit     = !procStrobeN && !chipEnN;
    ctrlHit     = !ctrlStrobeN && !chipEnN;
    ctl.load    = procHit || ctrlHit;
    ctl.advance = !advanceN && !ctl.load;
  end
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtl_t           ctl,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int LOW_W = 2;
  localparam int UP_W  = ADDR_W - LOW_W;

  logic [UP_W-1:0]  upperQ;
  logic [LOW_W-1:0] startQ;
  logic [LOW_W-1:0] beatQ;
  logic             modeQ;
  logic [LOW_W-1:0] lowSeq;

  always_ff @(posedge clk) begin
    if (rst) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
      modeQ  <= 1'b0;
    end else if (ctl.load) begin
      upperQ <= addrIn[ADDR_W-1:LOW_W];
      startQ <= addrIn[LOW_W-1:0];
      beatQ  <= '0;
      modeQ  <= interleave;
    end else if (ctl.advance) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  always_comb begin
    if (modeQ) lowSeq = startQ ^ beatQ;
    else       lowSeq = startQ + beatQ;
    addrOut = {upperQ, lowSeq};
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> addrOut == $past(addrIn));

  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> addrOut[ADDR_W-1:LOW_W] == $past(addrOut[ADDR_W-1:LOW_W]));

  // R8
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.load && !ctl.advance) |=> $stable(addrOut));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.advance && !modeQ) |=> addrOut[LOW_W-1:0] == LOW_W'($past(addrOut[LOW_W-1:0]) + 2'd1));

  // R6
  xor_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.advance && modeQ) |=>
      (addrOut[LOW_W-1:0] ^ $past(addrOut[LOW_W-1:0])) ==
      ($past(beatQ) ^ LOW_W'($past(beatQ) + 2'd1)));

  // R9
  mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> modeQ == $past(modeQ));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipEnN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  seqCtl_t ctl;

  burst_ctrl uCtrl (
    .chipEnN     (chipEnN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .ctl         (ctl)
  );

  burst_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .interleave (interleave),
    .addrIn     (addrIn),
    .addrOut    (addrOut)
  );

  // R3
  deselect_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (chipEnN && advanceN) |=> $stable(addrOut));

  // R4
  start_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!chipEnN && !procStrobeN && !advanceN) |=> addrOut == $past(addrIn));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int ADDR_W = 18;

  logic clk = 1'b0;
  logic rst, chipEnN, procStrobeN, ctrlStrobeN, advanceN, interleave;
  logic [ADDR_W-1:0] addrIn, addrOut;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .chipEnN(chipEnN), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .interleave(interleave),
    .addrIn(addrIn), .addrOut(addrOut)
  );

  // Drive at the falling edge, then sample 1 ns after the rising edge.
  task automatic cycle(input logic ce, input logic p, input logic c,
                       input logic a, input logic m, input logic [ADDR_W-1:0] ad);
    @(negedge clk);
    chipEnN = ce; procStrobeN = p; ctrlStrobeN = c; advanceN = a;
    interleave = m; addrIn = ad;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_addr(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (addrOut !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, addrOut, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cycle(1, 1, 1, 1, 0, '1);
    cycle(1, 1, 1, 1, 0, '1);
    expect_addr("R1", '0);
    rst = 1'b0;
  endtask

  task automatic t_linear;
    logic [ADDR_W-1:0] a = 18'h24A6E; // low pair 2
    cycle(0, 0, 1, 1, 0, a);
    expect_addr("R2", a);
    for (int n = 1; n <= 4; n++) begin
      cycle(0, 1, 1, 0, 1, '0); // interleave change mid-burst must not matter (R9)
      expect_addr(n == 4 ? "R7" : "R5", {a[ADDR_W-1:2], 2'(a[1:0] + n)});
    end
  endtask

  task automatic t_interleave;
    logic [ADDR_W-1:0] b = 18'h13C35; // low pair 1
    cycle(0, 1, 0, 1, 1, b);
    expect_addr("R2", b);
    for (int n = 1; n <= 4; n++) begin
      cycle(0, 1, 1, 0, 0, 18'h3FFFF);
      expect_addr(n == 4 ? "R7" : "R6", {b[ADDR_W-1:2], 2'(b[1:0] ^ n[1:0])});
    end
    cycle(0, 1, 1, 0, 0, '0);
    expect_addr("R9", {b[ADDR_W-1:2], 2'b00});
  endtask

  task automatic t_suspend;
    logic [ADDR_W-1:0] held;
    held = addrOut;
    for (int n = 0; n < 3; n++) begin
      cycle(0, 1, 1, 1, n[0], 18'h00F0F);
      expect_addr("R8", held);
    end
  endtask

  task automatic t_deselect;
    logic [ADDR_W-1:0] c = 18'h30F0B; // low pair 3
    cycle(0, 0, 1, 1, 0, c);
    expect_addr("R2", c);
    cycle(1, 0, 1, 1, 1, 18'h11111);
    expect_addr("R3", c);
    cycle(1, 1, 0, 1, 1, 18'h22222);
    expect_addr("R3", c);
    cycle(1, 0, 0, 0, 1, 18'h33333);
    expect_addr("R3", {c[ADDR_W-1:2], 2'b00});
  endtask

  task automatic t_collide;
    logic [ADDR_W-1:0] d = 18'h05551; // low pair 1
    logic [ADDR_W-1:0] e = 18'h2AAA2; // low pair 2
    cycle(0, 1, 1, 0, 0, '0); // step the running burst first
    cycle(0, 0, 0, 0, 0, d);
    expect_addr("R4", d);
    cycle(0, 1, 1, 0, 0, '0);
    expect_addr("R5", {d[ADDR_W-1:2], 2'b10});
    cycle(0, 1, 0, 0, 1, e);
    expect_addr("R4", e);
    cycle(0, 1, 1, 0, 0, '0);
    expect_addr("R6", {e[ADDR_W-1:2], 2'b11});
  endtask

  initial begin
    chipEnN = 1; procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1;
    interleave = 0; addrIn = '0; rst = 1;
    t_reset();
    t_linear();
    t_interleave();
    t_suspend();
    t_deselect();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule